// File: doc/BRIEF.md
# Backplane Node Register Window

This block sits on a register bus and answers accesses aimed at the configuration space of a sixteen-slot backplane. Every slot owns an 8 KiB region. The block splits each incoming address into a slot number and a byte offset inside that slot. For every populated slot it then serves three registers: a read-only device-type code, a writable control/status word, and a diagnostic word that always reads the same constant.

The window starts one slot above the backplane base. Window address zero therefore belongs to node 1, and node 0 is never reached. The control/status register has a field that names the node. That field always reads back as the node number decoded from the address, whatever value was last written to it.

Slots above the highest populated node do not claim an access. The block answers such an access with an error response, so the requester can raise a bus fault. Every request gets its response on the cycle after it is presented.

Top module: `bp_node_window`

## Requirements
- R1: After reset there is no response pending, and every control/status register holds zero. A read of a node's control/status register right after reset therefore returns only the node number in bits 3:0.
- R2: Each cycle with `req_valid` high produces exactly one response in the next cycle, with either `resp_ack` or `resp_err` high. Requests may arrive on back-to-back cycles. With no request, `resp_valid`, `resp_ack` and `resp_err` stay low.
- R3: The node number is `req_addr[16:13]` plus one, and the byte offset is `req_addr[12:0]`.
- R4: When the decoded node is above `MAX_NODE`, the response has `resp_err` high and `resp_rdata` zero. A write to such a node changes no stored state.
- R5: A read at offset 0x000 returns `TYPE_CODE` for node 1 and zero for every other node. Writes at that offset are acknowledged and change nothing.
- R6: A write at offset 0x004 stores all 32 bits in that node's own control/status register. A read at that offset returns stored bits 31:4, with bits 3:0 replaced by the decoded node number. Other nodes' registers are untouched.
- R7: A read at offset 0x0F4 returns 0x0000FFFF. Writes at that offset are acknowledged and ignored.
- R8: A read at any other offset of a populated node is acknowledged and returns zero. A write there is acknowledged and dropped.
- R9: Every write response carries `resp_rdata` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address inside the window |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response present, one cycle after the request |
| resp_ack | output | 1 | Access claimed by a populated node |
| resp_err | output | 1 | Access not claimed |
| resp_rdata | output | 32 | Read data; zero on writes and errors |

## Verification
The bench runs with three populated nodes, so it can show that control/status storage is kept per node. A decoder that dropped the one-slot shift would send a write to the wrong node; a later read of the neighbour would then show corrupted upper bits. Writes are made with nonzero low nibbles so that a missing node-number overlay shows up as a wrong field. The bench also sends writes to the type, diagnostic and unused offsets, to an unpopulated node, and to the last slot. A design that decoded those offsets too loosely would change a control/status value that the bench reads back afterwards, and one that claimed an empty slot would answer with an acknowledge instead of an error.

// File: rtl/bpw_pkg.sv
package bpw_pkg;
    parameter int DATA_W = 32;   // register width
    parameter int NID_W  = 4;    // width of the node field in the CSR

    typedef enum logic [1:0] {
        SEL_TYPE,
        SEL_CSR,
        SEL_DIAG,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              vld;
        logic              ack;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } resp_t;
endpackage

// File: rtl/bpw_decode.sv
module bpw_decode #(
    parameter int ADDR_W   = 17,
    parameter int OFF_W    = 13,
    parameter int MAX_NODE = 1,
    localparam int NODE_W  = ADDR_W - OFF_W + 1
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NODE_W-1:0]   node,
    output bpw_pkg::reg_sel_e   sel,
    output logic                hit
);
    localparam logic [OFF_W-1:0] OFF_TYPE = OFF_W'(13'h000);
    localparam logic [OFF_W-1:0] OFF_CSR  = OFF_W'(13'h004);
    localparam logic [OFF_W-1:0] OFF_DIAG = OFF_W'(13'h0F4);

    logic [OFF_W-1:0] off;

    always_comb begin
        // the window begins one slot up: slot field 0 is node 1
        node = {1'b0, addr[ADDR_W-1:OFF_W]} + NODE_W'(1);
        off  = addr[OFF_W-1:0];
        hit  = (node <= NODE_W'(MAX_NODE));
        if (off == OFF_TYPE)      sel = bpw_pkg::SEL_TYPE;
        else if (off == OFF_CSR)  sel = bpw_pkg::SEL_CSR;
        else if (off == OFF_DIAG) sel = bpw_pkg::SEL_DIAG;
        else                      sel = bpw_pkg::SEL_NONE;
    end
endmodule

// File: rtl/bpw_csr_bank.sv
module bpw_csr_bank #(
    parameter int NUM    = 1,
    parameter int NODE_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NODE_W-1:0] node,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] csr_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_csr
        logic [DATA_W-1:0] csr_d;
        logic              sel_w;

        always_comb begin
            sel_w = wr_en && (node == NODE_W'(g + 1));
            csr_d = sel_w ? wdata : csr_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) csr_q[g] <= '0;
            else        csr_q[g] <= csr_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM; i++) begin
            if (node == NODE_W'(i + 1)) rd_data = csr_q[i];
        end
    end
endmodule

// File: rtl/bp_node_window.sv
module bp_node_window #(
    parameter int                      ADDR_W    = 17,
    parameter int                      OFF_W     = 13,
    parameter int                      MAX_NODE  = 1,
    parameter logic [bpw_pkg::DATA_W-1:0] TYPE_CODE = 32'h0000_010E,
    parameter logic [bpw_pkg::DATA_W-1:0] DIAG_VAL  = 32'h0000_FFFF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [bpw_pkg::DATA_W-1:0] req_wdata,
    output logic                       resp_valid,
    output logic                       resp_ack,
    output logic                       resp_err,
    output logic [bpw_pkg::DATA_W-1:0] resp_rdata
);
    import bpw_pkg::*;

    localparam int NODE_W = ADDR_W - OFF_W + 1;
    localparam int NUM    = (MAX_NODE < 1) ? 1 : MAX_NODE;

    logic [NODE_W-1:0] node;
    reg_sel_e          sel;
    logic              hit;
    logic              csr_we;
    logic [DATA_W-1:0] csr_rd;
    resp_t             resp_d, resp_q;

    bpw_decode #(
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .MAX_NODE (MAX_NODE)
    ) u_decode (
        .addr (req_addr),
        .node (node),
        .sel  (sel),
        .hit  (hit)
    );

    assign csr_we = req_valid && req_write && hit && (sel == SEL_CSR);

    bpw_csr_bank #(
        .NUM    (NUM),
        .NODE_W (NODE_W),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (csr_we),
        .node    (node),
        .wdata   (req_wdata),
        .rd_data (csr_rd)
    );

    always_comb begin
        resp_d       = '0;
        resp_d.vld   = req_valid;
        resp_d.ack   = req_valid && hit;
        resp_d.err   = req_valid && !hit;
        if (req_valid && hit && !req_write) begin
            unique case (sel)
                SEL_TYPE: resp_d.rdata = (node == NODE_W'(1)) ? TYPE_CODE : '0;
                SEL_CSR:  resp_d.rdata = {csr_rd[DATA_W-1:NID_W], node[NID_W-1:0]};
                SEL_DIAG: resp_d.rdata = DIAG_VAL;
                default:  resp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign resp_valid = resp_q.vld;
    assign resp_ack   = resp_q.ack;
    assign resp_err   = resp_q.err;
    assign resp_rdata = resp_q.rdata;
endmodule

// File: rtl/bpw_checker.sv
module bpw_checker #(
    parameter int ADDR_W   = 17,
    parameter int OFF_W    = 13,
    parameter int MAX_NODE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              resp_valid,
    input logic              resp_ack,
    input logic              resp_err,
    input logic [31:0]       resp_rdata
);
    localparam int SLOT_W = ADDR_W - OFF_W;

    logic [SLOT_W-1:0] slot;
    logic [OFF_W-1:0]  offs;
    logic              empty_slot;
    assign slot       = req_addr[ADDR_W-1:OFF_W];
    assign offs       = req_addr[OFF_W-1:0];
    assign empty_slot = ({1'b0, slot} >= (SLOT_W + 1)'(MAX_NODE));

    AST_ONE_OF_ACK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_ack ^ resp_err)); // R2
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (!resp_ack && !resp_err)); // R2
    AST_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid); // R2
    AST_EMPTY_SLOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && empty_slot) |=> (resp_err && resp_rdata == 32'h0)); // R4
    AST_NODE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !empty_slot && offs == OFF_W'(4))
        |=> (resp_rdata[3:0] == 4'($past(slot)) + 4'd1)); // R6
    AST_DIAG_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !empty_slot && offs == OFF_W'(12'h0F4))
        |=> (resp_rdata == 32'h0000_FFFF)); // R7
    AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (resp_rdata == 32'h0)); // R9
endmodule

bind bp_node_window bpw_checker #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .MAX_NODE (MAX_NODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .resp_valid (resp_valid),
    .resp_ack   (resp_ack),
    .resp_err   (resp_err),
    .resp_rdata (resp_rdata)
);

// File: tb/bp_node_window_tb.sv
module bp_node_window_tb;
    localparam logic [31:0] TYPE = 32'h0000_010E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid, resp_ack, resp_err;
    logic [31:0] resp_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [32:0] exp_q [$];   // {ack, rdata}
    string       tag_q [$];

    always #4 clk = ~clk;     // 125 MHz

    bp_node_window #(.MAX_NODE(3), .TYPE_CODE(TYPE)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
        .resp_ack(resp_ack), .resp_err(resp_err), .resp_rdata(resp_rdata)
    );

    function automatic logic [16:0] wa(int node, int off);
        return 17'(((node - 1) << 13) | off);
    endfunction

    task automatic issue(bit wr, logic [16:0] a, logic [31:0] wd,
                         bit eack, logic [31:0] erd, string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        exp_q.push_back({eack, erd});
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2: unexpected response ack=%0b rdata=%h expected none",
                         resp_ack, resp_rdata);
            end else begin
                logic [32:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (resp_ack !== e[32] || resp_err !== !e[32] || resp_rdata !== e[31:0]) begin
                    errors++;
                    $display("FAIL %s: ack=%0b err=%0b rdata=%h expected ack=%0b err=%0b rdata=%h",
                             t, resp_ack, resp_err, resp_rdata, e[32], !e[32], e[31:0]);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (resp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: resp_valid=%0b during reset expected 0", resp_valid);
        end
        rst_n = 1'b1;

        // R1: CSRs zero after reset, node field overlaid
        issue(0, wa(1, 4), 0, 1, 32'h1, "R1");
        issue(0, wa(3, 4), 0, 1, 32'h3, "R1");
        // R5: type codes, R3 decode of node 2
        issue(0, wa(1, 0), 0, 1, TYPE, "R5");
        issue(0, wa(2, 0), 0, 1, 32'h0, "R5");
        issue(1, wa(1, 0), 32'hDEAD_BEEF, 1, 0, "R5");
        issue(0, wa(1, 0), 0, 1, TYPE, "R5");
        // R6 per-node storage with overlay, R9 write data zero
        issue(1, wa(1, 4), 32'hA5A5_5A5F, 1, 0, "R9");
        issue(1, wa(2, 4), 32'h1234_567C, 1, 0, "R6");
        issue(0, wa(1, 4), 0, 1, 32'hA5A5_5A51, "R6");
        issue(0, wa(2, 4), 0, 1, 32'h1234_5672, "R3");
        issue(0, wa(3, 4), 0, 1, 32'h3, "R6");
        // R7 diagnostic constant
        issue(0, wa(3, 12'h0F4), 0, 1, 32'h0000_FFFF, "R7");
        issue(1, wa(3, 12'h0F4), 32'h0BAD_0BAD, 1, 0, "R7");
        issue(0, wa(3, 12'h0F4), 0, 1, 32'h0000_FFFF, "R7");
        // R8 unused offsets
        issue(0, wa(1, 8), 0, 1, 32'h0, "R8");
        issue(1, wa(1, 8), 32'hFFFF_FFFF, 1, 0, "R8");
        issue(1, wa(1, 13'h1FFC), 32'hFFFF_FFF0, 1, 0, "R8");
        issue(0, wa(1, 13'h1FFC), 0, 1, 32'h0, "R8");
        issue(0, wa(1, 4), 0, 1, 32'hA5A5_5A51, "R8");
        // R4 unpopulated nodes
        issue(0, wa(4, 4), 0, 0, 32'h0, "R4");
        issue(1, wa(4, 4), 32'hFFFF_FFFF, 0, 0, "R4");
        issue(0, wa(16, 0), 0, 0, 32'h0, "R4");
        issue(1, wa(16, 4), 32'hCAFE_F00D, 0, 0, "R4");
        issue(0, wa(3, 4), 0, 1, 32'h3, "R4");
        issue(0, wa(2, 4), 0, 1, 32'h1234_5672, "R4");
        idle();
        // R2: no response without a request
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0 || resp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2: pending=%0d resp_valid=%0b expected 0 and 0",
                     exp_q.size(), resp_valid);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule